// File: doc/BRIEF.md
# AXI4 Handshake Protocol Checker

This block is a passive, synthesizable observer for one AXI4 link. It watches the five channels (write address, write data, write response, read address, read data) and flags the handshake rules that a source breaks. A source with VALID high and READY low must hold VALID and the channel payload until the handshake completes. A write response may only appear when a write address has already been accepted. No VALID may be high in the first cycle after reset.

All inputs are observed only. Each rule has its own bit in a sticky error vector that only reset clears. A single pulse output marks every cycle in which a rule failed. Both outputs are registered: a violation sampled at a rising edge shows on the outputs right after that same edge.

Top module: `axi_hs_monitor`

## Requirements
- R1: Write-address stability, bit 0. If awValid was high and awReady low at one edge, and at the next edge awValid is low or any of awAddr, awLen, awBurst differs, bit 0 sets.
- R2: Write-data stability, bit 1. The same rule as R1 applies to wValid/wReady with payload wData, wStrb, wLast.
- R3: Write-response stability, bit 2. The same rule as R1 applies to bValid/bReady with payload bResp.
- R4: Read-address stability, bit 3. The same rule as R1 applies to arValid/arReady with payload arAddr.
- R5: Read-data stability, bit 4. The same rule as R1 applies to rValid/rReady with payload rData, rLast.
- R6: Response ordering, bit 5. A count of accepted write addresses rises on each awValid&awReady edge and falls on each bValid&bReady edge. bValid high at an edge where the count, as set by earlier edges, is zero sets bit 5. A write-address handshake at that same edge does not count as earlier.
- R7: Reset rule, bit 6. At the first rising edge after rstN is released, any VALID that is high sets bit 6.
- R8: Both outputs are zero while in reset. A set bit of errSticky stays set until rstN is asserted.
- R9: errPulse is high for exactly the cycle after each edge at which at least one rule failed. It is low after an edge with no failure.
- R10: No rule fires when the source was not stalled at the previous edge (VALID low, or READY high). In that case VALID may drop and the payload may change freely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| awValid | input | 1 | Write address valid |
| awReady | input | 1 | Write address ready |
| awAddr | input | ADDR_W | Write address |
| awLen | input | LEN_W | Write burst length |
| awBurst | input | 2 | Write burst type |
| wValid | input | 1 | Write data valid |
| wReady | input | 1 | Write data ready |
| wData | input | DATA_W | Write data |
| wStrb | input | DATA_W/8 | Write byte strobes |
| wLast | input | 1 | Last write beat |
| bValid | input | 1 | Write response valid |
| bReady | input | 1 | Write response ready |
| bResp | input | 2 | Write response code |
| arValid | input | 1 | Read address valid |
| arReady | input | 1 | Read address ready |
| arAddr | input | ADDR_W | Read address |
| rValid | input | 1 | Read data valid |
| rReady | input | 1 | Read data ready |
| rData | input | DATA_W | Read data |
| rLast | input | 1 | Last read beat |
| errSticky | output | 7 | Sticky per-rule error bits, bit order as in R1 to R7 |
| errPulse | output | 1 | High for one cycle after any failing edge |

## Verification
Every channel is swept through the same set of patterns:
- a stalled beat held unchanged, which must stay silent;
- VALID dropped during a stall;
- each payload field changed on its own during a stall, which shows that each field is compared separately;
- a change after a cycle with READY high, which separates a real stall from a completed handshake.

Response ordering is driven with a B before any address, a B matched with one address, a second B after the count has drained, and two addresses followed by three responses, which exercises the count. The reset rule is driven with a VALID held high across reset release.

// File: rtl/axi_hs_pkg.sv
package axi_hs_pkg;
  localparam int NUM_CH    = 5;
  localparam int CH_AW     = 0;
  localparam int CH_W      = 1;
  localparam int CH_B      = 2;
  localparam int CH_AR     = 3;
  localparam int CH_R      = 4;
  localparam int RULE_ORD  = 5;
  localparam int RULE_RST  = 6;
  localparam int NUM_RULES = 7;

  // one strobe per channel: payload differs from the previous edge
  // (packed MSB first, so aw lands on bit CH_AW when cast to a vector)
  typedef struct packed {
    logic r;
    logic ar;
    logic b;
    logic w;
    logic aw;
  } payloadDelta_t;
endpackage

// File: rtl/axi_hs_datapath.sv
module axi_hs_datapath
  import axi_hs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   awAddr,
  input  logic [LEN_W-1:0]    awLen,
  input  logic [1:0]          awBurst,
  input  logic [DATA_W-1:0]   wData,
  input  logic [DATA_W/8-1:0] wStrb,
  input  logic                wLast,
  input  logic [1:0]          bResp,
  input  logic [ADDR_W-1:0]   arAddr,
  input  logic [DATA_W-1:0]   rData,
  input  logic                rLast,
  output payloadDelta_t       delta
);
  localparam int STRB_W = DATA_W / 8;

  logic [ADDR_W-1:0] awAddrQ;
  logic [LEN_W-1:0]  awLenQ;
  logic [1:0]        awBurstQ;
  logic [DATA_W-1:0] wDataQ;
  logic [STRB_W-1:0] wStrbQ;
  logic              wLastQ;
  logic [1:0]        bRespQ;
  logic [ADDR_W-1:0] arAddrQ;
  logic [DATA_W-1:0] rDataQ;
  logic              rLastQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      awAddrQ  <= '0;
      awLenQ   <= '0;
      awBurstQ <= '0;
      wDataQ   <= '0;
      wStrbQ   <= '0;
      wLastQ   <= 1'b0;
      bRespQ   <= '0;
      arAddrQ  <= '0;
      rDataQ   <= '0;
      rLastQ   <= 1'b0;
    end else begin
      awAddrQ  <= awAddr;
      awLenQ   <= awLen;
      awBurstQ <= awBurst;
      wDataQ   <= wData;
      wStrbQ   <= wStrb;
      wLastQ   <= wLast;
      bRespQ   <= bResp;
      arAddrQ  <= arAddr;
      rDataQ   <= rData;
      rLastQ   <= rLast;
    end
  end

  always_comb begin
    delta.aw = (awAddr != awAddrQ) | (awLen != awLenQ) | (awBurst != awBurstQ);
    delta.w  = (wData != wDataQ) | (wStrb != wStrbQ) | (wLast != wLastQ);
    delta.b  = (bResp != bRespQ);
    delta.ar = (arAddr != arAddrQ);
    delta.r  = (rData != rDataQ) | (rLast != rLastQ);
  end
endmodule

// File: rtl/axi_hs_control.sv
module axi_hs_control
  import axi_hs_pkg::*;
#(
  parameter int OUTST_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CH-1:0]    validNow,
  input  logic [NUM_CH-1:0]    readyNow,
  input  payloadDelta_t        delta,
  output logic [NUM_RULES-1:0] errSticky,
  output logic                 errPulse
);
  localparam logic [OUTST_W-1:0] OUTST_MAX = '1;

  logic [NUM_CH-1:0]    validPrev;
  logic [NUM_CH-1:0]    readyPrev;
  logic [NUM_CH-1:0]    deltaVec;
  logic [NUM_RULES-1:0] viol;
  logic [OUTST_W-1:0]   outstanding;
  logic                 firstCycle;
  logic                 awHs;
  logic                 bHs;

  assign deltaVec = delta;
  assign awHs     = validNow[CH_AW] & readyNow[CH_AW];
  assign bHs      = validNow[CH_B] & readyNow[CH_B];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_stab
    assign viol[ch] = validPrev[ch] & ~readyPrev[ch] & (~validNow[ch] | deltaVec[ch]);
  end

  assign viol[RULE_ORD] = validNow[CH_B] & (outstanding == '0);
  assign viol[RULE_RST] = firstCycle & (|validNow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validPrev   <= '0;
      readyPrev   <= '0;
      firstCycle  <= 1'b1;
      outstanding <= '0;
      errSticky   <= '0;
      errPulse    <= 1'b0;
    end else begin
      validPrev  <= validNow;
      readyPrev  <= readyNow;
      firstCycle <= 1'b0;
      errSticky  <= errSticky | viol;
      errPulse   <= |viol;
      if (awHs && !bHs && outstanding != OUTST_MAX) begin
        outstanding <= outstanding + 1'b1;
      end else if (bHs && !awHs && outstanding != '0) begin
        outstanding <= outstanding - 1'b1;
      end
    end
  end
endmodule

// File: rtl/axi_hs_monitor.sv
module axi_hs_monitor
  import axi_hs_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 8,
  parameter int OUTST_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 awValid,
  input  logic                 awReady,
  input  logic [ADDR_W-1:0]    awAddr,
  input  logic [LEN_W-1:0]     awLen,
  input  logic [1:0]           awBurst,
  input  logic                 wValid,
  input  logic                 wReady,
  input  logic [DATA_W-1:0]    wData,
  input  logic [DATA_W/8-1:0]  wStrb,
  input  logic                 wLast,
  input  logic                 bValid,
  input  logic                 bReady,
  input  logic [1:0]           bResp,
  input  logic                 arValid,
  input  logic                 arReady,
  input  logic [ADDR_W-1:0]    arAddr,
  input  logic                 rValid,
  input  logic                 rReady,
  input  logic [DATA_W-1:0]    rData,
  input  logic                 rLast,
  output logic [NUM_RULES-1:0] errSticky,
  output logic                 errPulse
);
  payloadDelta_t     delta;
  logic [NUM_CH-1:0] validVec;
  logic [NUM_CH-1:0] readyVec;

  assign validVec = {rValid, arValid, bValid, wValid, awValid};
  assign readyVec = {rReady, arReady, bReady, wReady, awReady};

  axi_hs_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LEN_W (LEN_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .awAddr (awAddr),
    .awLen  (awLen),
    .awBurst(awBurst),
    .wData  (wData),
    .wStrb  (wStrb),
    .wLast  (wLast),
    .bResp  (bResp),
    .arAddr (arAddr),
    .rData  (rData),
    .rLast  (rLast),
    .delta  (delta)
  );

  axi_hs_control #(
    .OUTST_W(OUTST_W)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .validNow (validVec),
    .readyNow (readyVec),
    .delta    (delta),
    .errSticky(errSticky),
    .errPulse (errPulse)
  );
endmodule

// File: rtl/axi_hs_monitor_checker.sv
module axi_hs_monitor_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              awValid,
  input logic              awReady,
  input logic              arValid,
  input logic              arReady,
  input logic              rValid,
  input logic              rReady,
  input logic [DATA_W-1:0] rData,
  input logic [6:0]        errSticky,
  input logic              errPulse
);
  AST_AW_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (awValid && !awReady) ##1 !awValid |=> errSticky[0]); // R1

  AST_AR_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (arValid && !arReady) ##1 !arValid |=> errSticky[3]); // R4

  AST_R_DATA_CHANGE_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !rReady) ##1 (rValid && !$stable(rData)) |=> errSticky[4]); // R5

  AST_STICKY_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    ((errSticky & $past(errSticky)) == $past(errSticky))); // R8

  AST_PULSE_HAS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (errSticky != 7'd0)); // R9
endmodule

bind axi_hs_monitor axi_hs_monitor_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .awValid  (awValid),
  .awReady  (awReady),
  .arValid  (arValid),
  .arReady  (arReady),
  .rValid   (rValid),
  .rReady   (rReady),
  .rData    (rData),
  .errSticky(errSticky),
  .errPulse (errPulse)
);

// File: tb/axi_hs_monitor_test.sv
`timescale 1ns/1ps
module axi_hs_monitor_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        awValid, awReady, wValid, wReady, wLast, bValid, bReady;
  logic        arValid, arReady, rValid, rReady, rLast;
  logic [31:0] awAddr, wData, arAddr, rData;
  logic [7:0]  awLen;
  logic [1:0]  awBurst, bResp;
  logic [3:0]  wStrb;
  logic [6:0]  errSticky;
  logic        errPulse;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  axi_hs_monitor uut (
    .clk(clk), .rstN(rstN),
    .awValid(awValid), .awReady(awReady), .awAddr(awAddr), .awLen(awLen), .awBurst(awBurst),
    .wValid(wValid), .wReady(wReady), .wData(wData), .wStrb(wStrb), .wLast(wLast),
    .bValid(bValid), .bReady(bReady), .bResp(bResp),
    .arValid(arValid), .arReady(arReady), .arAddr(arAddr),
    .rValid(rValid), .rReady(rReady), .rData(rData), .rLast(rLast),
    .errSticky(errSticky), .errPulse(errPulse)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string chTag(int ch);
    case (ch)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic int nFields(int ch);
    case (ch)
      0, 1: return 3;
      4: return 2;
      default: return 1;
    endcase
  endfunction

  task automatic idleAll();
    awValid = 0; awReady = 0; awAddr = 32'h1000; awLen = 8'd3; awBurst = 2'd1;
    wValid = 0; wReady = 0; wData = 32'hA5A5_0001; wStrb = 4'hF; wLast = 0;
    bValid = 0; bReady = 0; bResp = 2'd0;
    arValid = 0; arReady = 0; arAddr = 32'h2000;
    rValid = 0; rReady = 0; rData = 32'h0000_1234; rLast = 0;
  endtask

  // drive one channel; fld selects the single payload field to alter (-1: none)
  task automatic driveCh(int ch, logic v, logic rd, int fld);
    idleAll();
    case (ch)
      0: begin
        awValid = v; awReady = rd;
        if (fld == 0) awAddr = 32'h1040;
        if (fld == 1) awLen = 8'd7;
        if (fld == 2) awBurst = 2'd2;
      end
      1: begin
        wValid = v; wReady = rd;
        if (fld == 0) wData = 32'hA5A5_8001;
        if (fld == 1) wStrb = 4'h3;
        if (fld == 2) wLast = 1'b1;
      end
      2: begin
        bValid = v; bReady = rd;
        if (fld == 0) bResp = 2'd2;
      end
      3: begin
        arValid = v; arReady = rd;
        if (fld == 0) arAddr = 32'h2040;
      end
      default: begin
        rValid = v; rReady = rd;
        if (fld == 0) rData = 32'h0000_5678;
        if (fld == 1) rLast = 1'b1;
      end
    endcase
  endtask

  task automatic doReset();
    rstN = 1'b0;
    idleAll();
    tick();
    tick();
    rstN = 1'b1;
    tick();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    idleAll();
    tick();
    check("R8 reset sticky", {25'd0, errSticky}, 32'd0);
    check("R8 reset pulse", {31'd0, errPulse}, 32'd0);
    doReset();

    // stability sweep over every channel and pattern
    for (int ch = 0; ch < 5; ch++) begin
      for (int m = 0; m < 3 + nFields(ch); m++) begin
        logic expV;
        // the B channel's ordering rule needs an accepted address first
        doReset();
        if (ch == 2) begin
          driveCh(0, 1, 1, -1);
          tick();
        end
        driveCh(ch, 1'b1, (m == 2), -1);
        tick();
        case (m)
          0: begin driveCh(ch, 1, 0, -1); expV = 0; end
          1: begin driveCh(ch, 0, 0, -1); expV = 1; end
          2: begin driveCh(ch, 0, 0, 0);  expV = 0; end
          default: begin driveCh(ch, 1, 0, m - 3); expV = 1; end
        endcase
        tick();
        check($sformatf("%s/R9 pulse ch%0d m%0d", chTag(ch), ch, m), {31'd0, errPulse}, {31'd0, expV});
        check($sformatf("%s/R10 sticky ch%0d m%0d", chTag(ch), ch, m),
              {25'd0, errSticky}, expV ? (32'd1 << ch) : 32'd0);
        if (expV) begin
          // hold the just-seen values as a steady stall or idle: no new failure
          tick();
          check($sformatf("R9 pulse falls ch%0d m%0d", ch, m), {31'd0, errPulse}, 32'd0);
          check($sformatf("R8 sticky holds ch%0d m%0d", ch, m), {25'd0, errSticky}, 32'd1 << ch);
        end
      end
    end

    // R6 ordering: B with nothing accepted
    doReset();
    driveCh(2, 1, 1, -1);
    tick();
    check("R6 B before any AW", {25'd0, errSticky}, 32'd1 << 5);
    check("R6/R9 pulse", {31'd0, errPulse}, 32'd1);

    // R6: AW then B is legal, a second B is not
    doReset();
    driveCh(0, 1, 1, -1);
    tick();
    driveCh(2, 1, 1, -1);
    tick();
    check("R6 B after one AW", {25'd0, errSticky}, 32'd0);
    tick();
    check("R6 second B after drain", {25'd0, errSticky}, 32'd1 << 5);

    // R6: two addresses, three responses
    doReset();
    driveCh(0, 1, 1, -1);
    tick();
    tick();
    driveCh(2, 1, 1, -1);
    tick();
    tick();
    check("R6 two B after two AW", {25'd0, errSticky}, 32'd0);
    tick();
    check("R6 third B", {25'd0, errSticky}, 32'd1 << 5);
    idleAll();
    tick();
    tick();
    check("R8 sticky persists idle", {25'd0, errSticky}, 32'd1 << 5);
    check("R9 pulse idle", {31'd0, errPulse}, 32'd0);

    // R7: VALID high across reset release
    for (int ch = 0; ch < 5; ch += 4) begin
      rstN = 1'b0;
      idleAll();
      tick();
      driveCh(ch, 1, 1, -1);
      tick();
      check("R8 in reset", {25'd0, errSticky}, 32'd0);
      rstN = 1'b1;
      tick();
      check($sformatf("R7 valid after reset ch%0d", ch), {25'd0, errSticky}, 32'd1 << 6);
      check("R7/R9 pulse", {31'd0, errPulse}, 32'd1);
    end

    // R7 quiet when valids low
    doReset();
    check("R7 quiet release", {25'd0, errSticky}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule